// File: doc/BRIEF.md
# Single-Level Paged Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address through a page table it holds itself, with 16 entries. The upper four address bits select one entry directly. The entry supplies a 3-bit frame number, which replaces the page number. The 12-bit offset within the page passes through unchanged. Each entry also holds five flags: present, read-only, no-cache, referenced and modified.

A requester sends one access per cycle over a valid/ready handshake and marks each access as a read or a write. Exactly one cycle after an access is accepted, a registered response appears. It carries a status:

- success, with the physical address and the entry's no-cache flag;
- a page fault, when the entry is not present;
- a protection fault, when the access writes to a read-only page.

Every response reports the virtual page number. On each successful access the hardware marks the entry as referenced, and on a successful write it also marks it as modified. Faulting accesses leave the entry untouched.

Software reaches the table through a configuration port. In one cycle it can either overwrite a whole entry or clear the referenced flag of every entry. The same port reads back the entry selected by its index at any time. Handling faults and choosing pages to evict are left to software.

Top module: `pgx_translator`

## Requirements
- R1: Bits [15:12] of the virtual address select the table entry, and bits [11:0] are the offset within the page.
- R2: An access whose entry has present=0 returns status 1 (page fault), and the physical address output is 0.
- R3: An access to a present entry that is allowed returns status 0. The physical address is {frame, offset}, and the no-cache output equals the entry's no-cache flag.
- R4: A write to an entry with read-only=1 returns status 2 (protection fault), and the physical address is 0. Reads of that entry succeed.
- R5: A successful access sets the entry's referenced flag. A successful write also sets its modified flag.
- R6: A faulting access leaves the entry's flags unchanged. Every response reports the accessed virtual page number on rsp_vpn_o.
- R7: The entry word is laid out as [2:0] frame, [3] present, [4] read-only, [5] no-cache, [6] referenced, [7] modified. A configuration write stores the word at cfg_idx_i. cfg_rdata_o always shows the entry at cfg_idx_i.
- R8: A clear command resets the referenced flag of all 16 entries in one cycle and keeps every other field. A write issued in the same cycle takes effect on its own entry.
- R9: req_ready_o is low in any cycle with a configuration write or clear. The response is valid exactly in the cycle after each accepted access and low otherwise.
- R10: After reset every entry reads 0 and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write the entry word to the table |
| cfg_clr_i | input | 1 | Clear the referenced flag of all entries |
| cfg_idx_i | input | 4 | Entry index for write and read-back |
| cfg_wdata_i | input | 8 | Entry word to write |
| cfg_rdata_o | output | 8 | Entry word at cfg_idx_i |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Request can be accepted |
| req_vaddr_i | input | 16 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_status_o | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_paddr_o | output | 15 | Physical address (0 on a fault) |
| rsp_nocache_o | output | 1 | No-cache flag of the translated page |
| rsp_vpn_o | output | 4 | Virtual page number of the access |

## Verification
The bench builds the block with its default parameters: a 4-bit page number, a 12-bit offset and a 3-bit frame. With those values the whole table of 16 entries can be swept exhaustively.

Each page gets its own mix of flags: present or absent, read-only or writable, cached or not, and a frame number. Every page is then read and written at the lowest, middle and highest offsets. The referenced and modified flags are followed in a model kept in the bench after each access. Clearing, write/clear overlap, configuration stalls and idle cycles are checked last.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_PAGE_FAULT = 2'd1,
    ST_PROT_FAULT = 2'd2
  } xl_status_e;

  // flag positions above the frame field in an entry word
  localparam int unsigned FL_PRESENT = 0;
  localparam int unsigned FL_RO      = 1;
  localparam int unsigned FL_NC      = 2;
  localparam int unsigned FL_REF     = 3;
  localparam int unsigned FL_MOD     = 4;
  localparam int unsigned FLAG_W     = 5;
endpackage

// File: rtl/pgx_table.sv
module pgx_table
  import pgx_pkg::*;
#(
  parameter int unsigned PAGE_W  = 4,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned ENTRIES = 1 << PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_clr_i,
  input  logic [PAGE_W-1:0]  cfg_idx_i,
  input  logic [FRAME_W-1:0] cfg_frame_i,
  input  logic [FLAG_W-1:0]  cfg_flags_i,
  input  logic               upd_en_i,
  input  logic [PAGE_W-1:0]  upd_idx_i,
  input  logic               upd_write_i,
  output logic [FRAME_W-1:0] frame_o [ENTRIES],
  output logic [FLAG_W-1:0]  flags_o [ENTRIES]
);
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [FLAG_W-1:0]  flags_q [ENTRIES];
  logic [ENTRIES-1:0] ref_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        frame_q[i] <= '0;
        flags_q[i] <= '0;
      end else begin
        if (cfg_clr_i) flags_q[i][FL_REF] <= 1'b0;
        if (cfg_we_i && cfg_idx_i == PAGE_W'(i)) begin
          frame_q[i] <= cfg_frame_i;
          flags_q[i] <= cfg_flags_i;
        end else if (upd_en_i && upd_idx_i == PAGE_W'(i)) begin
          flags_q[i][FL_REF] <= 1'b1;
          if (upd_write_i) flags_q[i][FL_MOD] <= 1'b1;
        end
      end
    end
    assign frame_o[i] = frame_q[i];
    assign flags_o[i] = flags_q[i];
    assign ref_vec[i] = flags_q[i][FL_REF];
  end

  a_r5_ref_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !cfg_we_i && !cfg_clr_i) |=> flags_q[$past(upd_idx_i)][FL_REF]);
  a_r5_mod_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_write_i && !cfg_we_i && !cfg_clr_i) |=> flags_q[$past(upd_idx_i)][FL_MOD]);
  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_clr_i && !cfg_we_i && !upd_en_i) |=> ref_vec == '0);
endmodule

// File: rtl/pgx_lookup.sv
module pgx_lookup
  import pgx_pkg::*;
#(
  parameter int unsigned PAGE_W  = 4,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned ENTRIES = 1 << PAGE_W,
  localparam int unsigned VA_W    = PAGE_W + OFF_W,
  localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic               write_i,
  input  logic [FRAME_W-1:0] frame_i [ENTRIES],
  input  logic [FLAG_W-1:0]  flags_i [ENTRIES],
  output logic [PAGE_W-1:0]  vpn_o,
  output xl_status_e         status_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic               nocache_o
);
  logic [FRAME_W-1:0] sel_frame;
  logic [FLAG_W-1:0]  sel_flags;

  assign vpn_o     = vaddr_i[VA_W-1:OFF_W];
  assign sel_frame = frame_i[vpn_o];
  assign sel_flags = flags_i[vpn_o];

  always_comb begin
    status_o  = ST_OK;
    paddr_o   = '0;
    nocache_o = 1'b0;
    if (!sel_flags[FL_PRESENT]) begin
      status_o = ST_PAGE_FAULT;
    end else if (write_i && sel_flags[FL_RO]) begin
      status_o = ST_PROT_FAULT;
    end else begin
      paddr_o   = {sel_frame, vaddr_i[OFF_W-1:0]};
      nocache_o = sel_flags[FL_NC];
    end
  end
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
#(
  parameter int unsigned PAGE_W  = 4,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned ENTRIES = 1 << PAGE_W,
  localparam int unsigned VA_W    = PAGE_W + OFF_W,
  localparam int unsigned PA_W    = FRAME_W + OFF_W,
  localparam int unsigned WORD_W  = FRAME_W + FLAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_clr_i,
  input  logic [PAGE_W-1:0] cfg_idx_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              rsp_nocache_o,
  output logic [PAGE_W-1:0] rsp_vpn_o
);
  logic [FRAME_W-1:0] frame_w [ENTRIES];
  logic [FLAG_W-1:0]  flags_w [ENTRIES];
  logic [PAGE_W-1:0]  dec_vpn;
  xl_status_e         dec_status;
  logic [PA_W-1:0]    dec_paddr;
  logic               dec_nc;
  logic               fire;
  logic               upd_en;

  // config has priority over traffic
  assign req_ready_o = !(cfg_we_i || cfg_clr_i);
  assign fire        = req_valid_i && req_ready_o;
  assign upd_en      = fire && dec_status == ST_OK;
  assign cfg_rdata_o = {flags_w[cfg_idx_i], frame_w[cfg_idx_i]};

  pgx_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_clr_i   (cfg_clr_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_frame_i (cfg_wdata_i[FRAME_W-1:0]),
    .cfg_flags_i (cfg_wdata_i[WORD_W-1:FRAME_W]),
    .upd_en_i    (upd_en),
    .upd_idx_i   (dec_vpn),
    .upd_write_i (req_write_i),
    .frame_o     (frame_w),
    .flags_o     (flags_w)
  );

  pgx_lookup #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_lookup (
    .vaddr_i   (req_vaddr_i),
    .write_i   (req_write_i),
    .frame_i   (frame_w),
    .flags_i   (flags_w),
    .vpn_o     (dec_vpn),
    .status_o  (dec_status),
    .paddr_o   (dec_paddr),
    .nocache_o (dec_nc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_status_o  <= ST_OK;
      rsp_paddr_o   <= '0;
      rsp_nocache_o <= 1'b0;
      rsp_vpn_o     <= '0;
    end else begin
      rsp_valid_o <= fire;
      if (fire) begin
        rsp_status_o  <= dec_status;
        rsp_paddr_o   <= dec_paddr;
        rsp_nocache_o <= dec_nc;
        rsp_vpn_o     <= dec_vpn;
      end
    end
  end

  a_r9_rsp_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);
  a_r9_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !rsp_valid_o);
  a_r9_cfg_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i || cfg_clr_i) |-> !req_ready_o);
  a_r3_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_status_o != ST_OK ||
             rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]));
  a_r2_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != ST_OK) |-> rsp_paddr_o == '0);
  a_r6_fault_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec_status != ST_OK) |=> flags_w[$past(dec_vpn)] == $past(flags_w[dec_vpn]));
  a_r6_vpn_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_vpn_o == $past(req_vaddr_i[VA_W-1:OFF_W]));
endmodule

// File: tb/pgx_translator_tb.sv
module pgx_translator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_clr = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        rsp_valid, rsp_nc;
  logic [1:0]  rsp_status;
  logic [14:0] rsp_paddr;
  logic [3:0]  rsp_vpn;

  int checks = 0, failures = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgx_translator u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_clr_i(cfg_clr), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status),
    .rsp_paddr_o(rsp_paddr), .rsp_nocache_o(rsp_nc), .rsp_vpn_o(rsp_vpn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] idx, input logic [7:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    model[idx] = w;
  endtask

  task automatic readback(input logic [3:0] idx, input string req);
    @(negedge clk);
    cfg_idx = idx;
    #1;
    chk(req, {24'd0, cfg_rdata}, {24'd0, model[idx]});
  endtask

  task automatic access(input logic [15:0] va, input logic wr);
    logic [7:0] e;
    logic [1:0] st;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    e  = model[va[15:12]];
    st = !e[3] ? 2'd1 : (wr && e[4]) ? 2'd2 : 2'd0;
    chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R1/R6 vpn", {28'd0, rsp_vpn}, {28'd0, va[15:12]});
    if (st == 2'd1) chk("R2 page fault", {30'd0, rsp_status}, 32'd1);
    else if (st == 2'd2) chk("R4 prot fault", {30'd0, rsp_status}, 32'd2);
    else chk("R3 ok status", {30'd0, rsp_status}, 32'd0);
    if (st == 2'd0) begin
      chk("R3 paddr", {17'd0, rsp_paddr}, {17'd0, e[2:0], va[11:0]});
      chk("R3 nocache", {31'd0, rsp_nc}, {31'd0, e[5]});
      model[va[15:12]][6] = 1'b1;
      if (wr) model[va[15:12]][7] = 1'b1;
    end else begin
      chk("R2/R4 paddr zero", {17'd0, rsp_paddr}, 32'd0);
    end
    cfg_idx = va[15:12];
    #1;
    chk(st == 2'd0 ? "R5 flags" : "R6 flags kept", {24'd0, cfg_rdata}, {24'd0, model[va[15:12]]});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R9 ready idle", {31'd0, req_ready}, 32'd1);
    for (int i = 0; i < 16; i++) readback(4'(i), "R10 entry zero");
    // fault on empty table
    access(16'h5abc, 1'b0);
    // program all entries: layout [2:0] frame [3] present [4] ro [5] nc (R7)
    for (int i = 0; i < 16; i++) begin
      logic [7:0] w;
      w = {2'b00, 1'(i[0] ^ i[2]), 1'(i % 4 == 1), 1'(i % 3 != 0), 3'((i * 5) & 7)};
      cfg_write(4'(i), w);
    end
    for (int i = 0; i < 16; i++) readback(4'(i), "R7 readback");
    // sweep pages, offsets and directions
    for (int p = 0; p < 16; p++) begin
      for (int o = 0; o < 3; o++) begin
        logic [11:0] off;
        off = (o == 0) ? 12'h000 : (o == 1) ? 12'h7ff : 12'hfff;
        access({4'(p), off}, 1'b0);
        access({4'(p), off}, 1'b1);
      end
    end
    // clear all referenced flags (R8)
    @(negedge clk);
    cfg_clr = 1'b1;
    #1;
    chk("R9 ready low on clear", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    cfg_clr = 1'b0;
    for (int i = 0; i < 16; i++) model[i][6] = 1'b0;
    for (int i = 0; i < 16; i++) readback(4'(i), "R8 clear keeps others");
    access(16'h1234, 1'b0);
    // clear and write together: write wins on its entry (R8)
    access(16'h2000, 1'b0);
    @(negedge clk);
    cfg_clr = 1'b1; cfg_we = 1'b1; cfg_idx = 4'd4; cfg_wdata = 8'h4e;
    @(negedge clk);
    cfg_clr = 1'b0; cfg_we = 1'b0;
    for (int i = 0; i < 16; i++) model[i][6] = 1'b0;
    model[4] = 8'h4e;
    readback(4'd4, "R8 write wins");
    readback(4'd2, "R8 other cleared");
    // request stalled by config write (R9)
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd7; cfg_wdata = 8'h0b;
    req_valid = 1'b1; req_vaddr = 16'h7010; req_write = 1'b1;
    #1;
    chk("R9 ready low on write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    model[7] = 8'h0b;
    chk("R9 no rsp when stalled", {31'd0, rsp_valid}, 32'd0);
    readback(4'd7, "R9 stalled access left flags");
    access(16'h7010, 1'b1);
    @(negedge clk);
    chk("R9 idle no rsp", {31'd0, rsp_valid}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule